// File: doc/BRIEF.md
# Bus Arbiter Preemption Timer

This block tells a secondary-bus arbiter when it may take the grant away from the master that owns the bus. A 4-bit control field sets the delay. Software writes it, and the field can be read back. In the full configuration word it sits in the top nibble, bits 31:28. That placement is decoded outside this block, so only the nibble arrives here. The block also watches a flag that says FRAME is asserted on the bus, and a flag that says some other master wants the bus.

The three low bits of the field pick a delay of 0, 1, 2, 4, 8, 16, 32 or 64 cycles. The top bit turns preemption off. The block counts the clock edges at which FRAME has been seen asserted in the current transaction. It raises its enable output when three things hold: the chosen delay has passed, preemption is on, and another master is waiting. The arbiter then uses that output to remove the grant.

Top module: `arb_preempt_timer`

## Requirements
- R1: After reset the control field reads 4'b1000, which means preemption is off. The field changes only on a cycle with `cfg_wr_en` high; on any other cycle a value on `cfg_wr_field` has no effect.
- R2: When `cfg_wr_en` is high at a rising edge, `cfg_field` shows `cfg_wr_field` from the next cycle on.
- R3: While bit 3 of the field is 1, `preempt_en` stays 0 whatever bits 2:0, the count, `frame_active` and `other_req` hold.
- R4: With field 4'b0000, `preempt_en` is 1 in the very first cycle that `frame_active` is high, if `other_req` is high in that cycle.
- R5: With field values 1 to 7 in bits 2:0 and bit 3 clear, the delay N is 1, 2, 4, 8, 16, 32 and 64 cycles in that order. Let cycle 0 be the first cycle with `frame_active` high. Then `preempt_en` is first able to go high in cycle N, counting a cycle for each rising edge at which `frame_active` was sampled high.
- R6: A cycle with `frame_active` low clears the count, so the next transaction waits its whole delay again.
- R7: `preempt_en` is 1 only in a cycle where `frame_active` and `other_req` are both high.
- R8: The count stops at 64 and does not wrap. Once the delay has passed, preemption stays enabled for as long as FRAME stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Writes the control field at the next edge |
| cfg_wr_field | input | 4 | New control value: bit 3 turns preemption off, bits 2:0 select the delay |
| cfg_field | output | 4 | Current control field, for read-back |
| frame_active | input | 1 | High while FRAME is asserted on the bus |
| other_req | input | 1 | High while another master requests the bus |
| preempt_en | output | 1 | Arbiter may remove the current grant |

## Verification
The assertions check on every cycle the rules that concern one cycle or one step of the count. The off bit always blocks the output. The output needs both FRAME and a waiting requester. The field takes a write on the next cycle and holds its value otherwise. The count clears, steps and saturates as it should, and code zero enables preemption at once. The exact cycle at which each delay first opens needs the bench, which drives full transactions for every code. The same goes for the restart when FRAME drops in the middle of a delay, for long bursts that run past saturation, and for random mixes of writes, bursts and requests.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned FIELD_W   = SEL_W + 1;
  localparam int unsigned MAX_SHIFT = (1 << SEL_W) - 2;
  localparam int unsigned MAX_DELAY = 1 << MAX_SHIFT;
  localparam int unsigned CNT_W     = $clog2(MAX_DELAY + 1);

  typedef logic [FIELD_W-1:0] ctrl_t;
  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  localparam ctrl_t CTRL_RESET = ctrl_t'(1) << SEL_W;
  localparam cnt_t  CNT_TOP    = cnt_t'(MAX_DELAY);

  // Select code to delay: zero for code 0, otherwise 2^(code-1).
  function automatic cnt_t delay_of(input sel_t sel);
    cnt_t d;
    if (sel == '0) d = '0;
    else           d = cnt_t'(1) << (sel - sel_t'(1));
    return d;
  endfunction

  // Increment that holds at the terminal count.
  function automatic cnt_t sat_inc(input cnt_t c);
    cnt_t r;
    if (c >= CNT_TOP) r = CNT_TOP;
    else              r = c + cnt_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/apt_ctrl_reg.sv
module apt_ctrl_reg
  import apt_pkg::*;
#(
  parameter ctrl_t RESET_VAL = CTRL_RESET
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_field,
  output ctrl_t field_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     field_q <= RESET_VAL;
    else if (wr_en) field_q <= wr_field;
  end
endmodule

// File: rtl/apt_frame_counter.sv
module apt_frame_counter
  import apt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_active,
  output cnt_t count_q,
  output logic at_top
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count_q <= '0;
    else if (!frame_active) count_q <= '0;
    else                   count_q <= sat_inc(count_q);
  end

  assign at_top = (count_q == CNT_TOP);
endmodule

// File: rtl/apt_enable_logic.sv
module apt_enable_logic
  import apt_pkg::*;
(
  input  ctrl_t field,
  input  cnt_t  count,
  input  logic  frame_active,
  input  logic  other_req,
  output logic  preempt_off,
  output logic  delay_met,
  output logic  preempt_en
);
  cnt_t threshold;

  always_comb begin
    threshold   = delay_of(field[SEL_W-1:0]);
    preempt_off = field[FIELD_W-1];
    delay_met   = frame_active && (count >= threshold);
    preempt_en  = delay_met && !preempt_off && other_req;
  end
endmodule

// File: rtl/arb_preempt_timer.sv
module arb_preempt_timer
  import apt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [FIELD_W-1:0] cfg_wr_field,
  output logic [FIELD_W-1:0] cfg_field,
  input  logic               frame_active,
  input  logic               other_req,
  output logic               preempt_en
);
  cnt_t count_q;
  logic at_top;
  logic preempt_off;
  logic delay_met;

  apt_ctrl_reg #(.RESET_VAL(CTRL_RESET)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_field (cfg_wr_field),
    .field_q  (cfg_field)
  );

  apt_frame_counter u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .count_q      (count_q),
    .at_top       (at_top)
  );

  apt_enable_logic u_en (
    .field        (cfg_field),
    .count        (count_q),
    .frame_active (frame_active),
    .other_req    (other_req),
    .preempt_off  (preempt_off),
    .delay_met    (delay_met),
    .preempt_en   (preempt_en)
  );
endmodule

// File: rtl/apt_checker.sv
module apt_checker
  import apt_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  cfg_wr_en,
  input ctrl_t cfg_wr_field,
  input ctrl_t cfg_field,
  input logic  frame_active,
  input logic  other_req,
  input logic  preempt_en,
  input cnt_t  count_q,
  input logic  at_top
);
  assert_field_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_field));

  assert_field_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_field == $past(cfg_wr_field));

  assert_off_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_field[FIELD_W-1] |-> !preempt_en);

  assert_zero_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_field == '0 && frame_active && other_req) |-> preempt_en);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !at_top) |=> count_q == $past(count_q) + cnt_t'(1));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> count_q == '0);

  assert_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_en |-> (other_req && frame_active));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && at_top) |=> count_q == CNT_TOP);
endmodule

bind arb_preempt_timer apt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_field (cfg_wr_field),
  .cfg_field    (cfg_field),
  .frame_active (frame_active),
  .other_req    (other_req),
  .preempt_en   (preempt_en),
  .count_q      (count_q),
  .at_top       (at_top)
);

// File: tb/tb_arb_preempt_timer.sv
module tb_arb_preempt_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr_en;
  logic [3:0] cfg_wr_field;
  logic [3:0] cfg_field;
  logic       frame_active;
  logic       other_req;
  logic       preempt_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic [3:0] m_field;
  int         m_cnt;

  always #4 clk = ~clk;

  arb_preempt_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_field (cfg_wr_field),
    .cfg_field    (cfg_field),
    .frame_active (frame_active),
    .other_req    (other_req),
    .preempt_en   (preempt_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_field <= 4'b1000;
      m_cnt   <= 0;
    end else begin
      if (cfg_wr_en) m_field <= cfg_wr_field;
      if (!frame_active)   m_cnt <= 0;
      else if (m_cnt < 64) m_cnt <= m_cnt + 1;
    end
  end

  function automatic int wait_cycles(input logic [2:0] code);
    int w = 1;
    if (code == 3'd0) return 0;
    for (int k = 1; k < code; k++) w = w * 2;
    return w;
  endfunction

  function automatic logic expect_pre();
    return !m_field[3] && frame_active && other_req &&
           (m_cnt >= wait_cycles(m_field[2:0]));
  endfunction

  function automatic string tag_now();
    if (m_field[3])           return "R3";
    if (!other_req)           return "R7";
    if (!frame_active)        return "R6";
    if (m_field == 4'd0)      return "R4";
    if (m_cnt >= 64)          return "R8";
    return "R5";
  endfunction

  task automatic check_pre(input string tag);
    logic e;
    e = expect_pre();
    checks++;
    if (preempt_en !== e) begin
      errors++;
      $display("FAIL %s: preempt_en=%0b expected=%0b (field=%b cnt=%0d)",
               tag, preempt_en, e, m_field, m_cnt);
    end
  endtask

  task automatic check_field(input string tag, input logic [3:0] e);
    checks++;
    if (cfg_field !== e) begin
      errors++;
      $display("FAIL %s: cfg_field=%b expected=%b", tag, cfg_field, e);
    end
  endtask

  // one cycle: drive at the falling edge, check after settling
  task automatic step(input logic f, input logic r);
    @(negedge clk);
    frame_active = f;
    other_req    = r;
    cfg_wr_field = 4'($urandom);
    #1;
    check_pre(tag_now());
  endtask

  task automatic write_field(input logic [3:0] v);
    @(negedge clk);
    cfg_wr_en    = 1'b1;
    cfg_wr_field = v;
    frame_active = 1'b0;
    other_req    = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    check_field("R2", v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wr_field = 4'h0;
    frame_active = 1'b0;
    other_req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_field("R1", 4'b1000);
    checks++;
    if (preempt_en !== 1'b0) begin
      errors++;
      $display("FAIL R1: preempt_en=%0b expected=0 in reset", preempt_en);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value means off, even with frame and request held
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    // R1: field ignores data without the write enable
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1);
      check_field("R1", 4'b1000);
    end

    // R3: every off code blocks, long burst
    for (int c = 8; c < 16; c++) begin
      write_field(4'(c));
      for (int i = 0; i < 70; i++) step(1'b1, 1'b1);
    end

    // R4 and R5: first opening cycle for every delay code
    for (int c = 0; c < 8; c++) begin
      int first;
      first = -1;
      write_field(4'(c));
      for (int i = 0; i < 70; i++) begin
        step(1'b1, 1'b1);
        if (preempt_en && first < 0) first = i;
      end
      checks++;
      if (first != wait_cycles(3'(c))) begin
        errors++;
        $display("FAIL %s: first open cycle=%0d expected=%0d (code %0d)",
                 (c == 0) ? "R4" : "R5", first, wait_cycles(3'(c)), c);
      end
    end

    // R6: frame drop mid-delay restarts the count
    write_field(4'd3);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1);
      checks++;
      if (preempt_en !== 1'b0) begin
        errors++;
        $display("FAIL R6: preempt_en=1 expected=0 at restart cycle %0d", i);
      end
    end
    step(1'b1, 1'b1);

    // R7: no request, no preempt even after the delay
    write_field(4'd1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);

    // R8: long burst past saturation
    write_field(4'd7);
    for (int i = 0; i < 200; i++) step(1'b1, (i % 5) != 2);

    // random transactions
    for (int t = 0; t < 300; t++) begin
      int len;
      if ($urandom_range(0, 3) == 0) write_field(4'($urandom));
      len = $urandom_range(0, 90);
      for (int i = 0; i < len; i++) step(1'b1, $urandom_range(0, 3) != 0);
      for (int i = 0; i < $urandom_range(1, 3); i++) step(1'b0, 1'($urandom));
    end

    finish_run();
  end
endmodule